// File: doc/BRIEF.md
# Serial Configuration EEPROM Loader

This block pulls a device's start-up image out of a three-wire serial EEPROM. It drives select, shift clock and serial data toward the memory itself, one line at a time, and samples the memory's serial output. After reset, and again whenever a load is requested, it first reads word 0 with a short address to find out how wide the memory's address is. It then reads the 64-word image, adds up the words and decides whether the image is valid.

When the sum is valid the block presents a 48-bit station address built from the first three words. When it is not valid, the address is all zeros. Between loads, a host can fetch any single word through a small request/response port. The speed of the serial lines is set by a parameter giving the number of system clocks in each half-period of the shift clock. Integrators choose it so that every edge gets at least one microsecond of settling.

Top module: `seeprom_loader`

## Requirements
- R1: `ee_pins[0]` is the shift clock, `ee_pins[1]` is chip select and `ee_pins[2]` is serial data toward the EEPROM. `ee_dout` is serial data from the EEPROM. While the engine is idle all three outputs are low.
- R2: Every access shifts a 13-bit read frame MSB first. Narrow mode sends `0000_110_aaaaaa` with a 6-bit address. Wide mode sends `00_110_aaaaaaaa` with an 8-bit address.
- R3: Data toward the EEPROM changes only while the shift clock is low. Each access gives exactly 29 clock pulses: 13 for the frame, then 16 for data. Data is taken MSB first at the end of each high phase of those 16 pulses.
- R4: Chip select is low for one half-period and then high for two half-periods before the first rising clock edge. It drops after the last data bit.
- R5: Each load begins by reading word 0 in narrow mode. A result of 0xFFFF selects wide mode for every later read, host reads included. Any other result selects narrow mode. Narrow mode applies from reset until the first probe completes.
- R6: `csum_ok` is 1 exactly when the sum of words 0..63, taken modulo 2^16, equals 0xBABA.
- R7: `station_addr` equals {word2, word1, word0}, so byte 0 at bits [7:0] is the low byte of word 0. It is all zeros whenever the sum check fails.
- R8: A load starts by itself after reset, and on `load_req` while idle. `busy` is high for the whole load. A load clears `csum_ok` and `station_addr` when it starts. `done` pulses for one cycle as `busy` falls. The results then hold until the next load.
- R9: While idle, `host_rd_req` reads the word at `host_addr`, using only bits [5:0] in narrow mode. `busy` is high during the read. `host_rd_data` appears with a one-cycle `host_rd_valid` pulse as `busy` falls.
- R10: A host request made while busy is dropped and yields no valid pulse. If `load_req` and `host_rd_req` arrive in the same idle cycle, the load is taken and the host request is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| load_req | input | 1 | Start an image load (taken when idle) |
| host_rd_req | input | 1 | Start a single-word read (taken when idle) |
| host_addr | input | 8 | Word address for the host read |
| host_rd_data | output | 16 | Word returned by the host read |
| host_rd_valid | output | 1 | One-cycle pulse marking host_rd_data |
| busy | output | 1 | Engine is running a load or a host read |
| done | output | 1 | One-cycle pulse at the end of a load |
| csum_ok | output | 1 | Image sum matched 0xBABA |
| station_addr | output | 48 | Station address, zero on a bad image |
| ee_pins | output | 3 | Shift clock [0], chip select [1], data to EEPROM [2] |
| ee_dout | input | 1 | Serial data from the EEPROM |

## Verification
A load request and a host read request can land in the same idle cycle. A host request can also arrive while a load is in flight. The bench provokes both on purpose. It raises the two requests on one falling edge, and it issues host requests a few dozen cycles into a load. The outcome is judged at the ports: the load must run to its done pulse, and the count of valid pulses must not change at all. A behavioural EEPROM model in the bench accepts both 6-bit and 8-bit address frames. It returns all ones when the frame is too short for its own address width. This lets the probe-and-switch path be judged from the words that come back.

// File: rtl/seeprom_loader.sv
module seeprom_loader #(
  parameter int          HALF_CYC    = 4,
  parameter int          WORDS       = 64,
  parameter logic [15:0] CSUM_TARGET = 16'hBABA
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        load_req,
  input  logic        host_rd_req,
  input  logic [7:0]  host_addr,
  output logic [15:0] host_rd_data,
  output logic        host_rd_valid,
  output logic        busy,
  output logic        done,
  output logic        csum_ok,
  output logic [47:0] station_addr,
  output logic [2:0]  ee_pins,
  input  logic        ee_dout
);
  localparam int DW = (HALF_CYC > 1) ? $clog2(HALF_CYC) : 1;
  localparam int IW = $clog2(WORDS) + 1;
  localparam logic [5:0] LAST_STEP = 6'd61;

  typedef enum logic [1:0] {S_IDLE, S_PROBE, S_SCAN, S_HOST} st_t;

  st_t            st;
  logic [DW-1:0]  div;
  logic [5:0]     step;
  logic [15:0]    shreg, sum;
  logic [7:0]     acc_addr;
  logic           wide;
  logic [IW-1:0]  idx;
  logic [47:0]    img;

  assign busy = (st != S_IDLE);

  wire        tick    = busy && (div == DW'(HALF_CYC - 1));
  wire        acc_end = tick && (step == LAST_STEP);
  wire [15:0] nsum    = sum + shreg;
  wire [12:0] frame   = (wide && st != S_PROBE) ? {2'b00, 3'b110, acc_addr}
                                                : {4'b0000, 3'b110, acc_addr[5:0]};
  wire [5:0]  ci      = (step - 6'd2) >> 1;
  wire        in_cmd  = (step >= 6'd2) && (step <= 6'd27);
  wire        in_dat  = (step >= 6'd29) && (step <= 6'd59);

  logic sk, cs, di;
  always_comb begin
    cs = busy && (step != 6'd0) && (step != LAST_STEP);
    sk = busy && step[0] && ((step >= 6'd3 && step <= 6'd27) || in_dat);
    di = busy && in_cmd && frame[4'd12 - ci[3:0]];
  end
  assign ee_pins = {di, cs, sk};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st            <= S_PROBE;
      div           <= '0;
      step          <= '0;
      shreg         <= '0;
      sum           <= '0;
      acc_addr      <= '0;
      wide          <= 1'b0;
      idx           <= '0;
      img           <= '0;
      done          <= 1'b0;
      csum_ok       <= 1'b0;
      station_addr  <= '0;
      host_rd_data  <= '0;
      host_rd_valid <= 1'b0;
    end else begin
      done          <= 1'b0;
      host_rd_valid <= 1'b0;
      if (st == S_IDLE) begin
        div  <= '0;
        step <= '0;
        if (load_req) begin
          st           <= S_PROBE;
          acc_addr     <= '0;
          csum_ok      <= 1'b0;
          station_addr <= '0;
        end else if (host_rd_req) begin
          st       <= S_HOST;
          acc_addr <= host_addr;
        end
      end else begin
        div <= tick ? '0 : div + 1'b1;
        if (tick) step <= acc_end ? 6'd0 : step + 6'd1;
        if (tick && step[0] && in_dat) shreg <= {shreg[14:0], ee_dout};
        if (acc_end) begin
          case (st)
            S_PROBE: begin
              wide     <= (shreg == 16'hFFFF);
              st       <= S_SCAN;
              idx      <= '0;
              sum      <= '0;
              acc_addr <= '0;
            end
            S_SCAN: begin
              sum <= nsum;
              if (idx == IW'(0)) img[15:0]  <= shreg;
              if (idx == IW'(1)) img[31:16] <= shreg;
              if (idx == IW'(2)) img[47:32] <= shreg;
              if (idx == IW'(WORDS - 1)) begin
                st           <= S_IDLE;
                done         <= 1'b1;
                csum_ok      <= (nsum == CSUM_TARGET);
                station_addr <= (nsum == CSUM_TARGET) ? img : '0;
              end else begin
                idx      <= idx + 1'b1;
                acc_addr <= 8'(idx + 1'b1);
              end
            end
            default: begin
              host_rd_data  <= shreg;
              host_rd_valid <= 1'b1;
              st            <= S_IDLE;
            end
          endcase
        end
      end
    end
  end

  p_idle_pins_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> ee_pins == 3'b000);
  p_di_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (ee_pins[0] && $past(ee_pins[0])) |-> $stable(ee_pins[2]));
  p_addr_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !csum_ok) |-> station_addr == '0);
  p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  p_done_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
  p_valid_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    host_rd_valid |-> !busy);
endmodule

// File: tb/seeprom_loader_test.sv
module seeprom_loader_test;
  localparam int HALF = 4;
  logic clk = 0, rst_n = 0, load_req = 0, host_rd_req = 0;
  logic [7:0] host_addr = 0;
  logic [15:0] host_rd_data;
  logic host_rd_valid, busy, done, csum_ok;
  logic [47:0] station_addr;
  logic [2:0] ee_pins;
  logic ee_dout = 1'b1;
  wire ee_sk = ee_pins[0], ee_cs = ee_pins[1], ee_di = ee_pins[2];

  seeprom_loader #(.HALF_CYC(HALF)) uut (
    .clk(clk), .rst_n(rst_n), .load_req(load_req), .host_rd_req(host_rd_req),
    .host_addr(host_addr), .host_rd_data(host_rd_data), .host_rd_valid(host_rd_valid),
    .busy(busy), .done(done), .csum_ok(csum_ok), .station_addr(station_addr),
    .ee_pins(ee_pins), .ee_dout(ee_dout));

  always #4 clk = ~clk;

  int checks = 0, errs = 0;
  logic [15:0] mem [0:255];
  int maw = 6;

  // behavioural serial EEPROM plus frame monitor
  int ecnt = 0, nb = 0, outi = -1, last_edges = 0;
  logic started = 0, okf = 0;
  logic [9:0] cmdsh = 0;
  logic [7:0] maddr = 0;
  logic [12:0] frsh = 0, last_frame = 0;
  always @(posedge ee_sk or negedge ee_cs) begin
    if (!ee_cs) begin
      last_edges = ecnt; last_frame = frsh;
      ecnt = 0; started = 0; nb = 0; outi = -1; frsh = 0; ee_dout = 1'b1;
    end else begin
      ecnt++;
      if (ecnt <= 13) frsh = {frsh[11:0], ee_di};
      if (outi >= 0) begin
        ee_dout = okf ? mem[maddr][outi] : 1'b1;
        outi--;
      end else if (!started) begin
        if (ee_di) begin started = 1; nb = 0; cmdsh = 0; end
      end else if (nb < 2 + maw) begin
        cmdsh = {cmdsh[8:0], ee_di};
        nb++;
        if (nb == 2 + maw) begin
          okf   = (ecnt <= 13) && (cmdsh[maw+1 -: 2] == 2'b10);
          maddr = (maw == 8) ? cmdsh[7:0] : {2'b00, cmdsh[5:0]};
          outi  = 15;
        end
      end
    end
  end

  // port monitors, sampled away from the active edge
  int valid_cnt = 0, done_double = 0, di_viol = 0, lead_cnt = 0, last_lead = 0;
  logic prev_done = 0, prev_sk = 0, prev_di = 0, counting = 0;
  always @(negedge clk) begin
    if (host_rd_valid) valid_cnt++;
    if (done && prev_done) done_double++;
    if (ee_sk && prev_sk && ee_di != prev_di) di_viol++;
    if (!ee_cs) begin counting = 1; lead_cnt = 0; end
    else if (counting) begin
      if (ee_sk) begin counting = 0; last_lead = lead_cnt; end
      else lead_cnt++;
    end
    prev_done = done; prev_sk = ee_sk; prev_di = ee_di;
  end

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] exp_sum();
    logic [15:0] s = 0;
    for (int i = 0; i < 64; i++) s += mem[i];
    return s;
  endfunction

  function automatic logic [47:0] exp_station();
    return (exp_sum() == 16'hBABA) ? {mem[2], mem[1], mem[0]} : 48'h0;
  endfunction

  task automatic fill_image(input int aw, input bit good);
    logic [15:0] s = 0;
    maw = aw;
    for (int i = 0; i < 256; i++) mem[i] = 16'($urandom);
    if (aw == 6) mem[0] = mem[0] & 16'h7FFF;
    for (int i = 0; i < 63; i++) s += mem[i];
    mem[63] = 16'hBABA - s;
    if (!good) mem[63] = mem[63] ^ 16'h0010;
  endtask

  task automatic wait_done();
    for (int i = 0; i < 40000; i++) begin
      @(negedge clk);
      if (done) return;
    end
    chk(0, "R8 done never seen", 0, 1);
  endtask

  task automatic pulse_load();
    @(negedge clk) load_req = 1;
    @(negedge clk) load_req = 0;
  endtask

  task automatic check_load(input string tag);
    chk(busy == 0, {tag, " R8 busy low at done"}, busy, 0);
    chk(csum_ok == (exp_sum() == 16'hBABA), {tag, " R6 checksum flag"}, csum_ok, exp_sum() == 16'hBABA);
    chk(station_addr == exp_station(), {tag, " R7 station address"}, station_addr, exp_station());
  endtask

  task automatic host_read(input logic [7:0] a, input string tag);
    logic [7:0] ea;
    logic [12:0] ef;
    int v0;
    bit got = 0;
    ea = (maw == 8) ? a : {2'b00, a[5:0]};
    ef = (maw == 8) ? {2'b00, 3'b110, a} : {4'b0000, 3'b110, a[5:0]};
    v0 = valid_cnt;
    @(negedge clk) begin host_rd_req = 1; host_addr = a; end
    @(negedge clk) host_rd_req = 0;
    chk(busy == 1, {tag, " R9 busy during read"}, busy, 1);
    for (int i = 0; i < 2000 && !got; i++) begin
      @(negedge clk);
      if (host_rd_valid) got = 1;
    end
    chk(got && host_rd_data == mem[ea], {tag, " R9 host word"}, host_rd_data, mem[ea]);
    chk(last_frame == ef, {tag, " R2 command frame"}, last_frame, ef);
    chk(last_edges == 29, {tag, " R3 clock pulses per access"}, last_edges, 29);
    @(negedge clk);
    chk(valid_cnt == v0 + 1, {tag, " R9 single valid pulse"}, valid_cnt, v0 + 1);
  endtask

  initial begin
    int v0;
    logic [47:0] hold_st;
    void'($urandom(32'h5EED1234));
    fill_image(6, 1);
    repeat (5) @(negedge clk);
    chk(ee_pins == 3'b000, "R1 pins low in reset", ee_pins, 0);
    rst_n = 1;
    @(negedge clk);
    chk(busy == 1 && done == 0 && csum_ok == 0 && station_addr == 0,
        "R8 reset state with automatic load", {busy, done, csum_ok}, 3'b100);
    wait_done();
    check_load("auto load");
    @(negedge clk);
    chk(ee_pins == 3'b000, "R1 pins idle after load", ee_pins, 0);
    chk(last_lead == 2 * HALF, "R4 select lead before first clock", last_lead, 2 * HALF);

    for (int k = 0; k < 6; k++) host_read(8'($urandom_range(255, 0)), "narrow R5");
    host_read(8'd0, "narrow word0");
    host_read(8'hFF, "narrow top");

    v0 = valid_cnt;
    pulse_load();
    repeat (30) @(negedge clk);
    @(negedge clk) begin host_rd_req = 1; host_addr = 8'd5; end
    @(negedge clk) host_rd_req = 0;
    wait_done();
    repeat (3) @(negedge clk);
    chk(valid_cnt == v0, "R10 host request while busy dropped", valid_cnt, v0);
    check_load("reload");

    v0 = valid_cnt;
    @(negedge clk) begin load_req = 1; host_rd_req = 1; host_addr = 8'd3; end
    @(negedge clk) begin load_req = 0; host_rd_req = 0; end
    chk(busy == 1, "R10 load taken on tie", busy, 1);
    wait_done();
    repeat (3) @(negedge clk);
    chk(valid_cnt == v0, "R10 host request dropped on tie", valid_cnt, v0);

    fill_image(6, 0);
    pulse_load();
    wait_done();
    check_load("bad image");
    chk(csum_ok == 0 && station_addr == 0, "R7 zero address on bad sum", station_addr, 0);

    fill_image(6, 1);
    pulse_load();
    wait_done();
    hold_st = station_addr;
    repeat (50) @(negedge clk);
    chk(station_addr == hold_st && csum_ok == 1, "R8 results hold", station_addr, hold_st);

    fill_image(8, 1);
    pulse_load();
    wait_done();
    check_load("wide part R5");
    for (int k = 0; k < 4; k++) host_read(8'($urandom_range(255, 64)), "wide R5");
    host_read(8'd1, "wide low");

    chk(di_viol == 0, "R3 data held while clock high", di_viol, 0);
    chk(done_double == 0, "R8 done is one cycle", done_double, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errs);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    checks++;
    errs++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errs);
    $finish;
  end
endmodule